// File: doc/BRIEF.md
# Paged Nonvolatile Array Erase and Program Controller

This block controls a small nonvolatile store. The store is split into equal pages and is modelled here as an internal byte array. A bus front end hands it one request at a time over a valid/ready channel. A request is either a single-byte program or a whole-page erase. Each request carries a 16-bit address.

The store sits in a window of the address space. The page is found from the offset into that window. An erase ignores the byte-within-page bits of its address. The erase opcode alone starts an erase; no enable bit has to be set first. An erase clears every byte of the chosen page to the erased value. This takes a long, fixed time, and `busy` is held high for all of it. `req_ready` is low while `busy` is high, so the front end can refuse its own accesses. A program request only lands on a byte that is still erased. A program to a byte that already holds data is thrown away and raises a sticky error flag.

Back-pressure rules: a request transfers on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` depends only on `busy`. The controller never stalls a request for any other reason. A request that is offered while `req_ready` is low is not transferred. It leaves no trace, and the front end may drop it or hold it. A separate read port returns any byte one cycle after its address is presented.

Top module: `eep_page_erase_ctrl`

## Requirements
- R1: After reset, `busy` and `wr_err` are low, `req_ready` is high, and every byte of the array reads as FFh.
- R2: `req_ready` is the inverse of `busy`. Any program or erase request offered while `busy` is high has no effect on the array, on `wr_err` or on the busy timing.
- R3: An address is in the window when it lies from 8000h to 81FFh. Its page is (address − 8000h) >> 5, and its byte within the page is the low 5 bits. Program and erase requests outside the window are ignored. A read outside the window returns FFh.
- R4: An erase sets all 32 bytes of the addressed page to FFh, whatever the low 5 address bits are. Every byte in the other pages keeps its value.
- R5: `req_op` selects the operation: 1 is erase and 0 is program. An accepted in-window erase drives `busy` high from the next cycle for exactly ERASE_CYCLES cycles. The erased page reads as FFh from the cycle in which `busy` falls.
- R6: A program request to a byte that reads FFh stores `req_wdata` there in one cycle, and `busy` stays low.
- R7: A program request to a byte that does not read FFh leaves the byte unchanged and sets `wr_err`. Once set, `wr_err` stays high until reset.
- R8: `rd_data` is registered. It shows the byte at the `rd_addr` sampled on the previous rising edge and does not follow `rd_addr` between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The controller can take a request (low while busy) |
| req_op | input | 1 | 1 = page erase, 0 = byte program |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Program data |
| rd_addr | input | 16 | Read port address |
| rd_data | output | 8 | Read data, one cycle after the address |
| busy | output | 1 | Page erase in progress |
| wr_err | output | 1 | Sticky flag: a program hit a byte that was already programmed |

## Verification
If the latched page index is wrong, the wrong 32 bytes turn to FFh in the cycle `busy` falls. A read of the affected pages shows this one cycle later. If the erase counter drifts, the width of the `busy` pulse changes, and the change is seen on `req_ready` in the cycle it falls. If the check for a programmed byte reads the wrong byte, `wr_err` either rises or stays low in error one cycle after the program request. A read of that byte shows stored data that is wrong.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic {
    OP_PROGRAM = 1'b0,
    OP_ERASE   = 1'b1
  } eep_op_e;
endpackage

// File: rtl/eep_addr_decode.sv
// Maps a bus address onto a byte index inside the array window.
module eep_addr_decode #(
  parameter int          ADDR_W    = 16,
  parameter int          NBYTES    = 512,
  parameter logic [15:0] BASE_ADDR = 16'h8000,
  localparam int         IW        = $clog2(NBYTES)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IW-1:0]     idx
);
  localparam logic [ADDR_W-1:0] BASE = BASE_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] SPAN = NBYTES[ADDR_W-1:0];

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = addr - BASE;
    hit    = (addr >= BASE) && (offset < SPAN);
    idx    = offset[IW-1:0];
  end
endmodule

// File: rtl/eep_erase_timer.sv
// Holds busy for exactly ERASE_CYCLES cycles after start; done marks the last one.
module eep_erase_timer #(
  parameter int ERASE_CYCLES = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = (ERASE_CYCLES > 1) ? $clog2(ERASE_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(ERASE_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= LOAD;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/eep_array.sv
// Byte store: per-byte flops, whole-page clear in one cycle, program-if-erased.
module eep_array #(
  parameter int  NPAGES     = 16,
  parameter int  PAGE_BYTES = 32,
  parameter int  DATA_W     = 8,
  localparam int NBYTES     = NPAGES * PAGE_BYTES,
  localparam int IW         = $clog2(NBYTES),
  localparam int PW         = $clog2(NPAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_reject,
  input  logic              er_en,
  input  logic [PW-1:0]     er_page,
  input  logic              rd_hit,
  input  logic [IW-1:0]     rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [DATA_W-1:0] ERASED = '1;

  logic [DATA_W-1:0] mem [NBYTES];
  logic              tgt_blank;

  assign tgt_blank = (mem[wr_idx] == ERASED);
  assign wr_reject = wr_en && !tgt_blank;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    localparam logic [PW-1:0] MY_PAGE = PW'(i / PAGE_BYTES);
    localparam logic [IW-1:0] MY_IDX  = IW'(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[i] <= ERASED;
      end else if (er_en && (er_page == MY_PAGE)) begin
        mem[i] <= ERASED;
      end else if (wr_en && (wr_idx == MY_IDX) && (mem[i] == ERASED)) begin
        mem[i] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= ERASED;
    else        rd_data <= rd_hit ? mem[rd_idx] : ERASED;
  end
endmodule

// File: rtl/eep_page_erase_ctrl.sv
module eep_page_erase_ctrl #(
  parameter int          ADDR_W       = 16,
  parameter int          DATA_W       = 8,
  parameter int          NPAGES       = 16,
  parameter int          PAGE_BYTES   = 32,
  parameter logic [15:0] BASE_ADDR    = 16'h8000,
  parameter int          ERASE_CYCLES = 2500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              wr_err
);
  import eep_pkg::*;

  localparam int NBYTES = NPAGES * PAGE_BYTES;
  localparam int IW     = $clog2(NBYTES);
  localparam int PW     = $clog2(NPAGES);
  localparam int OW     = $clog2(PAGE_BYTES);

  logic          req_hit, rd_hit;
  logic [IW-1:0] req_idx, rd_idx;
  logic          fire, do_prog, do_erase, wr_reject, er_done;
  logic [PW-1:0] er_page;
  eep_op_e       op;

  eep_addr_decode #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BASE_ADDR(BASE_ADDR)) u_req_dec (
    .addr(req_addr), .hit(req_hit), .idx(req_idx)
  );

  eep_addr_decode #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BASE_ADDR(BASE_ADDR)) u_rd_dec (
    .addr(rd_addr), .hit(rd_hit), .idx(rd_idx)
  );

  assign op        = eep_op_e'(req_op);
  assign req_ready = !busy;
  assign fire      = req_valid && req_ready && req_hit;
  assign do_prog   = fire && (op == OP_PROGRAM);
  assign do_erase  = fire && (op == OP_ERASE);

  eep_erase_timer #(.ERASE_CYCLES(ERASE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(do_erase), .busy(busy), .done(er_done)
  );

  // Page index latched at acceptance; byte bits of the address are dropped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        er_page <= '0;
    else if (do_erase) er_page <= req_idx[IW-1:OW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wr_err <= 1'b0;
    else if (wr_reject) wr_err <= 1'b1;
  end

  eep_array #(.NPAGES(NPAGES), .PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(do_prog), .wr_idx(req_idx), .wr_data(req_wdata), .wr_reject(wr_reject),
    .er_en(er_done), .er_page(er_page),
    .rd_hit(rd_hit), .rd_idx(rd_idx), .rd_data(rd_data)
  );
endmodule

// File: rtl/eep_page_erase_chk.sv
module eep_page_erase_chk #(
  parameter int          ADDR_W       = 16,
  parameter int          DATA_W       = 8,
  parameter int          NPAGES       = 16,
  parameter int          PAGE_BYTES   = 32,
  parameter logic [15:0] BASE_ADDR    = 16'h8000,
  parameter int          ERASE_CYCLES = 2500000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              busy,
  input logic              wr_err
);
  localparam logic [ADDR_W-1:0] BASE = BASE_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NPAGES * PAGE_BYTES);
  localparam int BW = $clog2(ERASE_CYCLES + 1) + 1;

  logic          req_in, rd_in;
  logic [BW-1:0] blen;

  assign req_in = (req_addr >= BASE) && ((req_addr - BASE) < SPAN);
  assign rd_in  = (rd_addr >= BASE) && ((rd_addr - BASE) < SPAN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    blen <= '0;
    else if (busy) blen <= blen + 1'b1;
    else           blen <= '0;
  end

  a_r2_ready_inverts_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready != busy);

  a_r2_idle_without_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(req_valid && req_op && req_in)) |=> !busy);

  a_r5_erase_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op && req_in) |=> busy);

  a_r5_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (blen == BW'(ERASE_CYCLES)));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err);

  a_r3_read_outside_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_in |=> (rd_data == '1));
endmodule

bind eep_page_erase_ctrl eep_page_erase_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NPAGES(NPAGES), .PAGE_BYTES(PAGE_BYTES),
  .BASE_ADDR(BASE_ADDR), .ERASE_CYCLES(ERASE_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_addr(req_addr), .rd_addr(rd_addr), .rd_data(rd_data),
  .busy(busy), .wr_err(wr_err)
);

// File: tb/tb_eep_page_erase_ctrl.sv
module tb_eep_page_erase_ctrl;
  localparam int E  = 8;
  localparam int NP = 16;
  localparam int PB = 32;
  localparam int NB = NP * PB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_op = 1'b0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0]  req_wdata = 8'h0;
  logic [15:0] rd_addr = 16'h0;
  logic [7:0]  rd_data;
  logic        busy;
  logic        wr_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] model [NB];

  always #4 clk = ~clk;

  eep_page_erase_ctrl #(.ERASE_CYCLES(E)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .wr_err(wr_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) % 255);
  endfunction

  function automatic logic [15:0] at(input int i);
    return 16'h8000 + 16'(i);
  endfunction

  // Called at a falling edge; returns at the falling edge after the transfer edge.
  task automatic send(input bit op, input logic [15:0] a, input logic [7:0] d);
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = a;
    req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v);
    rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic check_all(input string req);
    logic [7:0] v;
    for (int i = 0; i < NB; i++) begin
      rd(at(i), v);
      chk(v == model[i], req, v, model[i]);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    for (int i = 0; i < NB; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(wr_err == 1'b0, "R1 wr_err", wr_err, 0);
    check_all("R1 blank array");

    // R3: outside the window
    rd(16'h0000, v); chk(v == 8'hFF, "R3 read 0000", v, 8'hFF);
    rd(16'h7FFF, v); chk(v == 8'hFF, "R3 read 7FFF", v, 8'hFF);
    rd(16'h8200, v); chk(v == 8'hFF, "R3 read 8200", v, 8'hFF);
    rd(16'hFFFF, v); chk(v == 8'hFF, "R3 read FFFF", v, 8'hFF);
    send(1'b1, 16'h8200, 8'h00);
    chk(busy == 1'b0, "R3 erase outside", busy, 0);
    send(1'b1, 16'h7FE0, 8'h00);
    chk(busy == 1'b0, "R3 erase below", busy, 0);
    send(1'b0, 16'h7FFF, 8'h00);
    chk(wr_err == 1'b0, "R3 program outside", wr_err, 0);

    // R6: program every byte of every page
    for (int i = 0; i < NB; i++) begin
      send(1'b0, at(i), pat(i));
      chk(busy == 1'b0, "R6 no busy", busy, 0);
      model[i] = pat(i);
    end
    chk(wr_err == 1'b0, "R6 wr_err", wr_err, 0);
    check_all("R6 readback");

    // R8: registered read port
    rd_addr = at(5);
    @(posedge clk);
    @(negedge clk);
    chk(rd_data == model[5], "R8 latency", rd_data, model[5]);
    rd_addr = at(6);
    #1;
    chk(rd_data == model[5], "R8 holds between edges", rd_data, model[5]);
    @(negedge clk);

    // R4, R5, R2: erase each page with assorted low bits
    for (int p = 0; p < NP; p++) begin
      int lo;
      int other;
      lo = (p * 3 + 1) % PB;
      other = (p + 5) % NP;
      send(1'b1, at(p * PB + lo), 8'h00);
      chk(busy == 1'b1, "R5 busy rises", busy, 1);
      chk(req_ready == 1'b0, "R2 ready low", req_ready, 0);
      send(1'b0, at(p * PB + 2), 8'h11);
      send(1'b1, at(other * PB), 8'h00);
      n = 2;
      while (busy && n < 4 * E) begin
        n++;
        @(negedge clk);
      end
      chk(n == E, "R5 busy width", n, E);
      chk(wr_err == 1'b0, "R2 ignored while busy", wr_err, 0);
      for (int b = 0; b < PB; b++) model[p * PB + b] = 8'hFF;
      check_all("R4 page erase");
    end

    // R7: programmed byte protection
    send(1'b0, 16'h8123, 8'h5A);
    model[9'h123] = 8'h5A;
    rd(16'h8123, v); chk(v == 8'h5A, "R6 program erased byte", v, 8'h5A);
    chk(wr_err == 1'b0, "R6 no error", wr_err, 0);
    send(1'b0, 16'h8123, 8'hA5);
    chk(wr_err == 1'b1, "R7 error raised", wr_err, 1);
    rd(16'h8123, v); chk(v == 8'h5A, "R7 byte kept", v, 8'h5A);
    send(1'b0, 16'h8124, 8'h33);
    model[9'h124] = 8'h33;
    rd(16'h8124, v); chk(v == 8'h33, "R7 later program ok", v, 8'h33);
    chk(wr_err == 1'b1, "R7 sticky after program", wr_err, 1);
    send(1'b1, 16'h813F, 8'h00);
    while (busy) @(negedge clk);
    model[9'h123] = 8'hFF;
    model[9'h124] = 8'hFF;
    chk(wr_err == 1'b1, "R7 sticky after erase", wr_err, 1);
    check_all("R4 erase via top byte address");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule